// File: doc/BRIEF.md
# Transmit Queue Entry Scheduler

This block takes 32-bit queue words that host software writes when a transmit packet chain is ready. Each word names a descriptor slot, a channel, an urgency flag, a channel-revive flag and a three-bit tag. The block splits the word into these fields. It then places the slot number and tag in one of two small FIFOs for that channel: an urgent FIFO or a regular FIFO. Each channel also has a service-enable bit. The error logic can clear that bit, and a queue word carrying the revive flag sets it again.

A transmit engine asks for work by naming a channel. If the channel is in service, the scheduler takes the oldest urgent entry, or the oldest regular entry when no urgent entry is waiting. It presents that entry with the absolute descriptor address, formed from a programmable base plus sixteen bytes per slot. If nothing can be given, it answers with a one-cycle "nothing" pulse.

A three-state machine runs the request side. S_IDLE accepts a request (transition REQ_ACCEPT) and moves to S_SELECT. S_SELECT picks an entry. It goes to S_GRANT on PICK_URGENT or PICK_REGULAR. It returns to S_IDLE on NO_WORK, when the channel is out of service or both FIFOs are empty. S_GRANT holds the result and returns to S_IDLE on GRANT_TAKEN, when grant_ready is high.

Top module: `txq_sched`

## Requirements
- R1: Bits 15:0 of a queue word are a slot number. grant_addr equals base_addr + slot*16, modulo 2^32, using base_addr while the grant is shown. grant_index returns the slot number.
- R2: Bits 23:16 hold a channel code, where code n means channel n+1. grant_chan returns the code. A word whose code is NUM_CH or higher is discarded with no effect on any FIFO, enable bit or overflow bit.
- R3: Bit 24 = 1 marks an urgent entry. A granted urgent entry sets grant_prio. On a channel, every waiting urgent entry is granted before any waiting regular entry. Within each class, entries are granted in arrival order.
- R4: Bit 25 = 1 sets the channel's enable bit on the edge that accepts the word, before that word can be granted. This holds even if err_disable clears the same channel in that cycle. With bit 25 = 0, the enable bit is left as it is.
- R5: A high err_disable[c] clears chan_enable[c]. A request on a disabled channel gets req_none, and its queued entries are kept for after the channel is revived.
- R6: Bits 28:26 return unchanged on grant_status. Bits 31:29 have no effect on anything.
- R7: A word for a full FIFO is dropped and sets overflow[c]. overflow[c] stays set until reset.
- R8: While grant_valid is high and grant_ready is low, grant_valid and all grant fields hold steady. req_valid is taken only while req_ready is high.
- R9: After reset, req_ready = 1, grant_valid = 0, req_none = 0, all chan_enable bits = 1 and all overflow bits = 0.
- R10: A request on an enabled channel with both FIFOs empty gets a single req_none pulse and no grant. req_none and grant_valid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Byte base address of the descriptor area |
| entry_valid | input | 1 | A queue word is offered this cycle |
| entry_data | input | 32 | Queue word |
| err_disable | input | NUM_CH | Per-channel out-of-service strobe from error logic |
| req_valid | input | 1 | Transmit engine asks for work |
| req_chan | input | CHW | Channel code asked for |
| req_ready | output | 1 | Request can be taken |
| grant_valid | output | 1 | A chain is offered |
| grant_ready | input | 1 | Engine takes the offered chain |
| grant_addr | output | 32 | Absolute descriptor address |
| grant_index | output | 16 | Slot number |
| grant_chan | output | 8 | Channel code |
| grant_status | output | 3 | Tag from the queue word |
| grant_prio | output | 1 | Offered entry was urgent |
| req_none | output | 1 | One-cycle pulse: request answered with no work |
| chan_enable | output | NUM_CH | Per-channel in-service bits |
| overflow | output | NUM_CH | Per-channel sticky drop flags |

## Verification
A bad FIFO pointer or count shows up at the next grant on that channel: a wrong slot, a wrong tag, or a req_none where work was waiting, two cycles after the request. A wrong enable bit shows up at once on chan_enable, and at the next request as a grant or refusal that should not have happened. A broken urgent/regular choice appears as a grant_prio or slot order that differs from the bench's per-channel model within the same request sequence. Held-grant faults are caught during a stall of several cycles.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef struct packed {
        logic [15:0] idx;
        logic [2:0]  tag;
    } txq_item_t;

    typedef struct packed {
        logic [15:0] idx;
        logic [7:0]  chan;
        logic        prio;
        logic        revive;
        logic [2:0]  tag;
    } txq_fields_t;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SELECT = 2'd1,
        S_GRANT  = 2'd2
    } txq_state_e;
endpackage

// File: rtl/txq_entry_decode.sv
module txq_entry_decode
    import txq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [31:0] word,
    output txq_fields_t fields,
    output logic        in_range
);
    logic unused_hi;

    always_comb begin
        fields.idx    = word[15:0];
        fields.chan   = word[23:16];
        fields.prio   = word[24];
        fields.revive = word[25];
        fields.tag    = word[28:26];
        in_range      = ({24'd0, word[23:16]} < 32'(NUM_CH));
    end

    assign unused_hi = ^word[31:29];
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int W     = 19,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/txq_sched.sv
module txq_sched
    import txq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DEPTH  = 4,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       base_addr,
    input  logic              entry_valid,
    input  logic [31:0]       entry_data,
    input  logic [NUM_CH-1:0] err_disable,
    input  logic              req_valid,
    input  logic [CHW-1:0]    req_chan,
    output logic              req_ready,
    output logic              grant_valid,
    input  logic              grant_ready,
    output logic [31:0]       grant_addr,
    output logic [15:0]       grant_index,
    output logic [7:0]        grant_chan,
    output logic [2:0]        grant_status,
    output logic              grant_prio,
    output logic              req_none,
    output logic [NUM_CH-1:0] chan_enable,
    output logic [NUM_CH-1:0] overflow
);
    localparam int IW = $bits(txq_item_t);

    txq_fields_t f;
    logic        f_ok;
    txq_item_t   new_item;

    txq_entry_decode #(.NUM_CH(NUM_CH)) u_dec (
        .word(entry_data), .fields(f), .in_range(f_ok)
    );
    assign new_item = '{idx: f.idx, tag: f.tag};

    logic [NUM_CH-1:0] hit, push_p, push_n, pop_p, pop_n;
    logic [NUM_CH-1:0] empty_p, empty_n, full_p, full_n;
    txq_item_t         head_p [NUM_CH];
    txq_item_t         head_n [NUM_CH];

    txq_state_e      state, state_nx;
    logic [CHW-1:0]  sel_ch;
    logic            sel_ok, take_p, take_n;
    txq_item_t       g_item;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit[c]    = entry_valid && f_ok && (f.chan == 8'(c));
        assign push_p[c] = hit[c] && f.prio;
        assign push_n[c] = hit[c] && !f.prio;
        assign pop_p[c]  = take_p && (sel_ch == CHW'(c));
        assign pop_n[c]  = take_n && (sel_ch == CHW'(c));

        txq_fifo #(.W(IW), .DEPTH(DEPTH)) u_urgent (
            .clk(clk), .rst_n(rst_n), .push(push_p[c]), .din(new_item),
            .pop(pop_p[c]), .head(head_p[c]), .empty(empty_p[c]), .full(full_p[c])
        );
        txq_fifo #(.W(IW), .DEPTH(DEPTH)) u_regular (
            .clk(clk), .rst_n(rst_n), .push(push_n[c]), .din(new_item),
            .pop(pop_n[c]), .head(head_n[c]), .empty(empty_n[c]), .full(full_n[c])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_enable[c] <= 1'b1;
                overflow[c]    <= 1'b0;
            end else begin
                if (hit[c] && f.revive)   chan_enable[c] <= 1'b1;
                else if (err_disable[c])  chan_enable[c] <= 1'b0;
                if ((push_p[c] && full_p[c]) || (push_n[c] && full_n[c]))
                    overflow[c] <= 1'b1;
            end
        end
    end

    // Selection in S_SELECT: urgent first, regular next, nothing if out of service
    assign sel_ok = (32'(sel_ch) < 32'(NUM_CH)) && chan_enable[sel_ch];
    assign take_p = (state == S_SELECT) && sel_ok && !empty_p[sel_ch];
    assign take_n = (state == S_SELECT) && sel_ok && empty_p[sel_ch] && !empty_n[sel_ch];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_SELECT;
            S_SELECT: state_nx = (take_p || take_n) ? S_GRANT : S_IDLE;
            S_GRANT:  if (grant_ready) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_ch     <= '0;
            g_item     <= '0;
            grant_prio <= 1'b0;
            req_none   <= 1'b0;
        end else begin
            req_none <= 1'b0;
            unique case (state)
                S_IDLE:   if (req_valid) sel_ch <= req_chan;
                S_SELECT: begin
                    if (take_p) begin
                        g_item     <= head_p[sel_ch];
                        grant_prio <= 1'b1;
                    end else if (take_n) begin
                        g_item     <= head_n[sel_ch];
                        grant_prio <= 1'b0;
                    end else begin
                        req_none   <= 1'b1;
                    end
                end
                S_GRANT:  ;
                default:  ;
            endcase
        end
    end

    assign req_ready    = (state == S_IDLE);
    assign grant_valid  = (state == S_GRANT);
    assign grant_index  = g_item.idx;
    assign grant_status = g_item.tag;
    assign grant_chan   = 8'(sel_ch);
    assign grant_addr   = base_addr + {12'd0, g_item.idx, 4'd0};
endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
    parameter int NUM_CH = 4,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       base_addr,
    input logic              entry_valid,
    input logic [31:0]       entry_data,
    input logic [NUM_CH-1:0] err_disable,
    input logic              req_valid,
    input logic [CHW-1:0]    req_chan,
    input logic              req_ready,
    input logic              grant_valid,
    input logic              grant_ready,
    input logic [31:0]       grant_addr,
    input logic [15:0]       grant_index,
    input logic [7:0]        grant_chan,
    input logic [2:0]        grant_status,
    input logic              grant_prio,
    input logic              req_none,
    input logic [NUM_CH-1:0] chan_enable,
    input logic [NUM_CH-1:0] overflow
);
    logic [CHW-1:0] g_ch, e_ch;
    logic           e_ok;
    assign g_ch = grant_chan[CHW-1:0];
    assign e_ch = entry_data[16 +: CHW];
    assign e_ok = ({24'd0, entry_data[23:16]} < 32'(NUM_CH));

    p_grant_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !grant_ready |=> grant_valid && $stable(grant_index)
            && $stable(grant_chan) && $stable(grant_status) && $stable(grant_prio));

    p_addr_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_addr[3:0] == base_addr[3:0]);

    p_granted_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(chan_enable[g_ch]));

    p_revive_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        entry_valid && entry_data[25] && e_ok |=> chan_enable[$past(e_ch)]);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((overflow & $past(overflow)) == $past(overflow)));

    p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && req_none));

    p_req_only_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !req_ready);
endmodule

bind txq_sched txq_sched_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/txq_sched_tb.sv
module txq_sched_tb_top;
    localparam int NUM_CH = 4;
    localparam int DEPTH  = 4;
    localparam int CHW    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       base_addr = 32'h1000_0000;
    logic              entry_valid = 1'b0;
    logic [31:0]       entry_data = '0;
    logic [NUM_CH-1:0] err_disable = '0;
    logic              req_valid = 1'b0;
    logic [CHW-1:0]    req_chan = '0;
    logic              req_ready, grant_valid, grant_prio, req_none;
    logic              grant_ready = 1'b1;
    logic [31:0]       grant_addr;
    logic [15:0]       grant_index;
    logic [7:0]        grant_chan;
    logic [2:0]        grant_status;
    logic [NUM_CH-1:0] chan_enable, overflow;

    txq_sched #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) dut_i (.*);

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct packed {
        logic        none;
        logic [31:0] addr;
        logic [15:0] idx;
        logic [7:0]  ch;
        logic [2:0]  st;
        logic        pr;
    } exp_t;

    exp_t              exp_q[$];
    logic [18:0]       mq_p [NUM_CH][$];
    logic [18:0]       mq_n [NUM_CH][$];
    logic [NUM_CH-1:0] en_m  = '1;
    logic [NUM_CH-1:0] ovf_m = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [15:0] idx, input int ch, input bit pr,
                                       input bit rv, input logic [2:0] st, input logic [2:0] hi);
        return {hi, st, rv, pr, 8'(ch), idx};
    endfunction

    task automatic send(input bit ev, input logic [31:0] w, input logic [NUM_CH-1:0] em);
        int c;
        @(posedge clk); #1;
        entry_valid = ev; entry_data = w; err_disable = em;
        en_m &= ~em;
        c = int'(w[23:16]);
        if (ev && c < NUM_CH) begin
            if (w[25]) en_m[c] = 1'b1;
            if (w[24]) begin
                if (mq_p[c].size() < DEPTH) mq_p[c].push_back({w[15:0], w[28:26]});
                else ovf_m[c] = 1'b1;
            end else begin
                if (mq_n[c].size() < DEPTH) mq_n[c].push_back({w[15:0], w[28:26]});
                else ovf_m[c] = 1'b1;
            end
        end
        @(posedge clk); #1;
        entry_valid = 1'b0; err_disable = '0;
    endtask

    task automatic req(input int c, input bit wt);
        exp_t e;
        logic [18:0] it;
        e = '0;
        if (en_m[c] && mq_p[c].size() > 0) begin
            it = mq_p[c].pop_front(); e.pr = 1'b1;
        end else if (en_m[c] && mq_n[c].size() > 0) begin
            it = mq_n[c].pop_front(); e.pr = 1'b0;
        end else begin
            it = '0; e.none = 1'b1;
        end
        if (!e.none) begin
            e.idx = it[18:3]; e.st = it[2:0]; e.ch = 8'(c);
            e.addr = base_addr + {12'd0, it[18:3], 4'd0};
        end
        exp_q.push_back(e);
        @(posedge clk); #1;
        req_valid = 1'b1; req_chan = CHW'(c);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (wt) for (int k = 0; k < 20 && exp_q.size() > 0; k++) @(posedge clk);
        #1;
    endtask

    // Monitor: compares every answer against the scoreboard (R1 R2 R3 R5 R6 R10)
    always @(negedge clk) begin
        if (rst_n && ((grant_valid && grant_ready) || req_none)) begin
            exp_t a, e;
            a = {req_none, grant_addr, grant_index, grant_chan, grant_status, grant_prio};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected answer", 64'(a), 64'(0));
            end else begin
                e = exp_q.pop_front();
                if (e.none) chk(req_none && !grant_valid, "R5/R10 no-work answer", 64'(a), 64'(e));
                else        chk(a == e, "R1/R2/R3/R6 grant content", 64'(a), 64'(e));
            end
        end
    end

    initial begin
        #(200000 * 20);
        chk(1'b0, "watchdog", 64'(0), 64'(1));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [59:0] held;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(req_ready && !grant_valid && !req_none, "R9 handshake idle", {req_ready, grant_valid, req_none}, 3'b100);
        chk(chan_enable == '1, "R9 enables", 64'(chan_enable), 64'hF);
        chk(overflow == '0, "R9 overflow", 64'(overflow), 64'h0);

        // R1 R6: regular entries, tag returned, high bits ignored
        send(1, mk(16'h0001, 0, 0, 0, 3'd5, 3'd0), '0);
        send(1, mk(16'h0002, 0, 0, 0, 3'd3, 3'd7), '0);
        req(0, 1); req(0, 1);

        // R3: urgent entries before regular ones, FIFO order per class
        send(1, mk(16'h0010, 1, 0, 0, 3'd1, 3'd0), '0);
        send(1, mk(16'h0011, 1, 0, 0, 3'd2, 3'd0), '0);
        send(1, mk(16'h0020, 1, 1, 0, 3'd4, 3'd0), '0);
        send(1, mk(16'h0021, 1, 1, 0, 3'd6, 3'd0), '0);
        req(1, 1); req(1, 1);
        send(1, mk(16'h0022, 1, 1, 0, 3'd7, 3'd0), '0);
        req(1, 1); req(1, 1); req(1, 1);

        // R2: out-of-range code discarded; code 3 maps to the last channel
        send(1, mk(16'h0099, 255, 1, 1, 3'd0, 3'd0), 4'b0000);
        @(negedge clk);
        chk(overflow == '0 && chan_enable == '1, "R2 out-of-range word", {overflow, chan_enable}, 8'h0F);
        send(1, mk(16'h0033, 3, 0, 0, 3'd2, 3'd0), '0);
        req(3, 1);

        // R5 R4: out of service keeps entries; revive flag restores it
        send(0, '0, 4'b0100);
        @(negedge clk);
        chk(chan_enable == 4'b1011, "R5 error clears enable", 64'(chan_enable), 64'hB);
        send(1, mk(16'h0040, 2, 0, 0, 3'd1, 3'd0), '0);
        req(2, 1);
        send(1, mk(16'h0041, 2, 0, 1, 3'd2, 3'd0), '0);
        @(negedge clk);
        chk(chan_enable == 4'b1111, "R4 revive sets enable", 64'(chan_enable), 64'hF);
        req(2, 1); req(2, 1);
        send(0, '0, 4'b0100);
        send(1, mk(16'h0042, 2, 0, 0, 3'd3, 3'd0), '0);
        @(negedge clk);
        chk(chan_enable[2] == 1'b0, "R4 clear flag leaves enable", 64'(chan_enable), 64'hB);
        req(2, 1);
        send(1, mk(16'h0043, 2, 0, 1, 3'd4, 3'd0), 4'b0100);
        @(negedge clk);
        chk(chan_enable[2] == 1'b1, "R4 revive beats error clear", 64'(chan_enable), 64'hF);
        req(2, 1); req(2, 1);

        // R7: full FIFO drops and sets sticky overflow; R10 empty request
        for (int i = 0; i < DEPTH + 1; i++) send(1, mk(16'(16'h0050 + i), 3, 0, 0, 3'd0, 3'd0), '0);
        @(negedge clk);
        chk(overflow == ovf_m && ovf_m == 4'b1000, "R7 overflow set", 64'(overflow), 64'(ovf_m));
        for (int i = 0; i < DEPTH; i++) req(3, 1);
        req(3, 1);
        @(negedge clk);
        chk(overflow == 4'b1000, "R7 overflow sticky", 64'(overflow), 64'h8);

        // R8 hold under stall, R1 address wrap
        base_addr = 32'hFFFF_FFF0;
        send(1, mk(16'hFFFF, 0, 0, 0, 3'd2, 3'd0), '0);
        grant_ready = 1'b0;
        req(0, 0);
        for (int k = 0; k < 10 && !grant_valid; k++) @(negedge clk);
        @(negedge clk);
        held = {grant_addr, grant_index, grant_chan, grant_status, grant_prio};
        chk(grant_valid && !req_ready, "R8 grant offered", {grant_valid, req_ready}, 2'b10);
        repeat (3) @(negedge clk);
        chk(grant_valid && held == {grant_addr, grant_index, grant_chan, grant_status, grant_prio},
            "R8 grant stable while stalled", 64'(held), 64'(held));
        chk(grant_addr == 32'h000F_FFE0, "R1 address wraps", 64'(grant_addr), 64'h000FFFE0);
        @(posedge clk); #1 grant_ready = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R8 all answers seen", 64'(exp_q.size()), 64'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule